// File: doc/BRIEF.md
# Leveled Interrupt Priority Controller

This block holds interrupt requests grouped into priority levels. Each level owns a wide word of individual source bits, and a one-bit-per-level status vector records which levels currently hold anything. A single request port carries three operations: set a source bit, clear a source bit, and wipe everything. The status bit of a level drops only when the last source bit in that level is cleared.

Every cycle, combinational logic merges a software request vector with the external levels. It yields a level number and a summary mask, then decides whether the processor should be interrupted. The decision compares that level against the processor's current priority level. It is also suppressed while the low two bits of the program counter are nonzero, and while no level holds a request. When the processor takes the interrupt, the level and mask are captured and an info-pending flag is raised. A later update strobe copies them to the interrupt-ID and interrupt-status outputs and drops the flag.

Top module: `intc_level_ctrl`

## Requirements
- R1: A request with `req_op` = 2'b01 (post) and in-range level L and index S sets source bit S of level L, and `lvl_status[L]` reads 1 after the next rising edge.
- R2: A request with `req_op` = 2'b10 (clear) resets source bit S of level L. `lvl_status[L]` returns to 0 only when no other source bit of level L remains set.
- R3: A request with `req_op` = 2'b11 (clear-all) empties every level, and `lvl_status` is all zero after that single edge.
- R4: `irq` is 0 while `lvl_status` is zero, whatever `sw_req` holds.
- R5: `irq` is 0 while `pc_low` is nonzero.
- R6: Each set `sw_req[i]` with SW_LO <= i < SW_HI (defaults 1 and 16) maps to level i-SW_LO+1. The highest such bit sets `calc_level`, and every such bit is set in `calc_summary[i]`. Bits of `sw_req` outside that range are ignored.
- R7: For each set `lvl_status[i]` with EXT_LO <= i < EXT_HI (defaults 16 and 32), bit i is set in `calc_summary`. The highest such i becomes `calc_level` and overrides any software-derived level.
- R8: `irq` is 1 only when `calc_level` is nonzero and strictly greater than `cur_ipl`.
- R9: `take` while `irq` is 1 captures `calc_level` and `calc_summary` and sets `info_pend`. A later `upd` with `info_pend` set drives them onto `int_id` and `int_status` one edge later and clears `info_pend`.
- R10: A post or clear whose level is >= NUM_LVL or whose index is >= SRC_W changes no pending state and raises `err` for exactly one cycle.
- R11: `upd` while `info_pend` is 0 leaves `int_id` and `int_status` unchanged and raises `err` for one cycle.
- R12: Reset clears all pending words, `lvl_status`, `info_pend`, `int_id`, `int_status` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request port strobe |
| req_op | input | 2 | 01 post, 10 clear, 11 clear-all |
| req_lvl | input | LVL_W | Target level of the request |
| req_idx | input | IDX_W | Source bit within the level |
| sw_req | input | NUM_LVL | Software request vector |
| pc_low | input | 2 | Two low bits of the current program counter |
| cur_ipl | input | LVL_W | Current processor priority level |
| take | input | 1 | Processor accepts the interrupt |
| upd | input | 1 | Copy captured info to the outputs |
| lvl_status | output | NUM_LVL | One bit per non-empty level |
| irq | output | 1 | Interrupt request to the processor |
| calc_level | output | LVL_W | Level computed this cycle |
| calc_summary | output | NUM_LVL | Summary mask computed this cycle |
| info_pend | output | 1 | Captured info awaiting update |
| int_id | output | LVL_W | Interrupt-ID register |
| int_status | output | NUM_LVL | Interrupt-status register |
| err | output | 1 | One-cycle error pulse |

## Verification
The priority function is tried with an empty status vector plus software bits, which shows that the status gate masks a valid software level. A single external level alone and then combined with software bits shows that external levels always win, while the summary still collects both. A non-external level used only to open the gate lets the software mapping be read on its own, with the lowest, highest, below-range and above-range software bits. Priority-level ties against higher values, and both nonzero program-counter alignments, separate the strict comparison and the alignment gate from the level calculation itself.

// File: rtl/ilc_pkg.sv
package ilc_pkg;

   typedef enum logic [1:0] {
      OP_NONE    = 2'b00,
      OP_POST    = 2'b01,
      OP_CLR     = 2'b10,
      OP_CLR_ALL = 2'b11
   } ilc_op_e;

endpackage

// File: rtl/ilc_pend_store.sv
module ilc_pend_store
   import ilc_pkg::*;
#(
   parameter int NUM_LVL = 32,
   parameter int SRC_W   = 64,
   parameter int LVL_W   = 6,
   parameter int IDX_W   = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic [1:0]         req_op_i,
   input  logic [LVL_W-1:0]   req_lvl_i,
   input  logic [IDX_W-1:0]   req_idx_i,
   output logic [NUM_LVL-1:0] status_o,
   output logic               err_o
);

   localparam logic [LVL_W-1:0] LVL_LIM = LVL_W'(NUM_LVL);
   localparam logic [IDX_W-1:0] IDX_LIM = IDX_W'(SRC_W);

   logic             lvl_ok, idx_ok, range_ok;
   logic             op_post, op_clr, op_wipe, bad_req;
   logic [SRC_W-1:0] src_mask;
   logic             err_q;

   always_comb begin
      lvl_ok   = (req_lvl_i < LVL_LIM);
      idx_ok   = (req_idx_i < IDX_LIM);
      range_ok = lvl_ok && idx_ok;
      op_post  = req_valid_i && (ilc_op_e'(req_op_i) == OP_POST);
      op_clr   = req_valid_i && (ilc_op_e'(req_op_i) == OP_CLR);
      op_wipe  = req_valid_i && (ilc_op_e'(req_op_i) == OP_CLR_ALL);
      bad_req  = (op_post || op_clr) && !range_ok;
      src_mask = idx_ok ? (SRC_W'(1) << req_idx_i) : '0;
   end

   for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
      logic             hit;
      logic             post_hit, clr_hit;
      logic [SRC_W-1:0] word_q, word_nxt;
      logic             stat_q;

      always_comb begin
         hit      = range_ok && (req_lvl_i == LVL_W'(g));
         post_hit = op_post && hit;
         clr_hit  = op_clr && hit;
         word_nxt = word_q;
         if (post_hit)
            word_nxt = word_q | src_mask;
         else if (clr_hit)
            word_nxt = word_q & ~src_mask;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
            stat_q <= 1'b0;
         end else if (op_wipe) begin
            word_q <= '0;
            stat_q <= 1'b0;
         end else begin
            word_q <= word_nxt;
            if (post_hit)
               stat_q <= 1'b1;
            else if (clr_hit && (word_nxt == '0))
               stat_q <= 1'b0;
         end
      end

      assign status_o[g] = stat_q;

      // R1
      post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
         post_hit |=> stat_q);

      // R2
      level_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stat_q == (word_q != '0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err_q <= 1'b0;
      else
         err_q <= bad_req;
   end

   assign err_o = err_q;

   // R3
   wipe_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_wipe |=> (status_o == '0));

   // R10
   bad_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_req |=> $stable(status_o));

endmodule

// File: rtl/ilc_prio_eval.sv
module ilc_prio_eval #(
   parameter int NUM_LVL = 32,
   parameter int LVL_W   = 6,
   parameter int SW_LO   = 1,
   parameter int SW_HI   = 16,
   parameter int EXT_LO  = 16,
   parameter int EXT_HI  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_LVL-1:0] status_i,
   input  logic [NUM_LVL-1:0] sw_req_i,
   input  logic [1:0]         pc_low_i,
   input  logic [LVL_W-1:0]   cur_ipl_i,
   output logic               irq_o,
   output logic [LVL_W-1:0]   level_o,
   output logic [NUM_LVL-1:0] summary_o
);

   logic [LVL_W-1:0]   lvl;
   logic [NUM_LVL-1:0] sum;
   logic [NUM_LVL-1:0] ext_mask;

   always_comb begin
      lvl = '0;
      sum = '0;
      for (int i = SW_LO; i < SW_HI; i++) begin
         if (sw_req_i[i]) begin
            lvl    = LVL_W'(i - SW_LO + 1);
            sum[i] = 1'b1;
         end
      end
      for (int i = EXT_LO; i < EXT_HI; i++) begin
         if (status_i[i]) begin
            lvl    = LVL_W'(i);
            sum[i] = 1'b1;
         end
      end
   end

   always_comb begin
      ext_mask = '0;
      for (int i = EXT_LO; i < EXT_HI; i++)
         ext_mask[i] = 1'b1;
   end

   assign level_o   = lvl;
   assign summary_o = sum;
   assign irq_o     = (status_i != '0) && (pc_low_i == 2'b00) &&
                      (lvl != '0) && (lvl > cur_ipl_i);

   // R7
   ext_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_i & ext_mask) != '0) |-> (level_o >= LVL_W'(EXT_LO)));

   // R5
   pc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_low_i != 2'b00) |-> !irq_o);

   // R8
   ipl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (level_o > cur_ipl_i));

endmodule

// File: rtl/ilc_info_latch.sv
module ilc_info_latch #(
   parameter int NUM_LVL = 32,
   parameter int LVL_W   = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take_i,
   input  logic               irq_i,
   input  logic [LVL_W-1:0]   level_i,
   input  logic [NUM_LVL-1:0] summary_i,
   input  logic               upd_i,
   output logic               pend_o,
   output logic [LVL_W-1:0]   int_id_o,
   output logic [NUM_LVL-1:0] int_status_o,
   output logic               err_o
);

   logic               accept;
   logic               pend_q, err_q;
   logic [LVL_W-1:0]   hold_lvl_q, id_q;
   logic [NUM_LVL-1:0] hold_sum_q, st_q;

   assign accept = take_i && irq_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         hold_lvl_q <= '0;
         hold_sum_q <= '0;
         id_q       <= '0;
         st_q       <= '0;
         err_q      <= 1'b0;
      end else begin
         if (accept) begin
            hold_lvl_q <= level_i;
            hold_sum_q <= summary_i;
         end
         if (upd_i && pend_q) begin
            id_q <= hold_lvl_q;
            st_q <= hold_sum_q;
         end
         if (accept)
            pend_q <= 1'b1;
         else if (upd_i)
            pend_q <= 1'b0;
         err_q <= upd_i && !pend_q;
      end
   end

   assign pend_o       = pend_q;
   assign int_id_o     = id_q;
   assign int_status_o = st_q;
   assign err_o        = err_q;

   // R9
   accept_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> pend_o);

   // R9
   upd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && pend_o && !accept) |=> !pend_o);

   // R11
   stray_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_i && !pend_o) |=> ($stable(int_id_o) && $stable(int_status_o)));

endmodule

// File: rtl/intc_level_ctrl.sv
module intc_level_ctrl #(
   parameter  int NUM_LVL = 32,
   parameter  int SRC_W   = 64,
   parameter  int SW_LO   = 1,
   parameter  int SW_HI   = 16,
   parameter  int EXT_LO  = 16,
   parameter  int EXT_HI  = 32,
   localparam int LVL_W   = $clog2(NUM_LVL) + 1,
   localparam int IDX_W   = $clog2(SRC_W) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_op,
   input  logic [LVL_W-1:0]   req_lvl,
   input  logic [IDX_W-1:0]   req_idx,
   input  logic [NUM_LVL-1:0] sw_req,
   input  logic [1:0]         pc_low,
   input  logic [LVL_W-1:0]   cur_ipl,
   input  logic               take,
   input  logic               upd,
   output logic [NUM_LVL-1:0] lvl_status,
   output logic               irq,
   output logic [LVL_W-1:0]   calc_level,
   output logic [NUM_LVL-1:0] calc_summary,
   output logic               info_pend,
   output logic [LVL_W-1:0]   int_id,
   output logic [NUM_LVL-1:0] int_status,
   output logic               err
);

   initial begin
      prm_range_chk: assert (NUM_LVL >= 2 && SRC_W >= 1 &&
                             SW_LO >= 1 && SW_HI > SW_LO &&
                             SW_HI <= EXT_LO && EXT_HI > EXT_LO &&
                             EXT_HI <= NUM_LVL)
         else $error("intc_level_ctrl: inconsistent level ranges");
   end

   logic err_req, err_upd;

   ilc_pend_store #(
      .NUM_LVL (NUM_LVL),
      .SRC_W   (SRC_W),
      .LVL_W   (LVL_W),
      .IDX_W   (IDX_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid),
      .req_op_i    (req_op),
      .req_lvl_i   (req_lvl),
      .req_idx_i   (req_idx),
      .status_o    (lvl_status),
      .err_o       (err_req)
   );

   ilc_prio_eval #(
      .NUM_LVL (NUM_LVL),
      .LVL_W   (LVL_W),
      .SW_LO   (SW_LO),
      .SW_HI   (SW_HI),
      .EXT_LO  (EXT_LO),
      .EXT_HI  (EXT_HI)
   ) u_eval (
      .clk       (clk),
      .rst_n     (rst_n),
      .status_i  (lvl_status),
      .sw_req_i  (sw_req),
      .pc_low_i  (pc_low),
      .cur_ipl_i (cur_ipl),
      .irq_o     (irq),
      .level_o   (calc_level),
      .summary_o (calc_summary)
   );

   ilc_info_latch #(
      .NUM_LVL (NUM_LVL),
      .LVL_W   (LVL_W)
   ) u_info (
      .clk          (clk),
      .rst_n        (rst_n),
      .take_i       (take),
      .irq_i        (irq),
      .level_i      (calc_level),
      .summary_i    (calc_summary),
      .upd_i        (upd),
      .pend_o       (info_pend),
      .int_id_o     (int_id),
      .int_status_o (int_status),
      .err_o        (err_upd)
   );

   assign err = err_req || err_upd;

   // R4
   empty_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_status == '0) |-> !irq);

endmodule

// File: tb/intc_level_ctrl_test.sv
`timescale 1ns/1ps
module intc_level_ctrl_test;

   localparam int NL = 32;
   localparam int LW = 6;
   localparam int IW = 7;
   localparam int NV = 14;
   localparam int VW = 85;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'b00;
   logic [LW-1:0] req_lvl = '0;
   logic [IW-1:0] req_idx = '0;
   logic [NL-1:0] sw_req = '0;
   logic [1:0]    pc_low = 2'b00;
   logic [LW-1:0] cur_ipl = '0;
   logic          take = 1'b0;
   logic          upd = 1'b0;
   logic [NL-1:0] lvl_status;
   logic          irq;
   logic [LW-1:0] calc_level;
   logic [NL-1:0] calc_summary;
   logic          info_pend;
   logic [LW-1:0] int_id;
   logic [NL-1:0] int_status;
   logic          err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   intc_level_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_lvl(req_lvl), .req_idx(req_idx), .sw_req(sw_req), .pc_low(pc_low),
      .cur_ipl(cur_ipl), .take(take), .upd(upd), .lvl_status(lvl_status),
      .irq(irq), .calc_level(calc_level), .calc_summary(calc_summary),
      .info_pend(info_pend), .int_id(int_id), .int_status(int_status),
      .err(err)
   );

   always #10 clk = ~clk;

   // fields: posted level (63 = none), sw_req, cur_ipl, pc_low,
   //         expected irq, expected level, expected summary
   localparam logic [VW-1:0] VEC [0:NV-1] = '{
      {6'd63, 32'h0000_0000, 6'd0,  2'd0, 1'b0, 6'd0,  32'h0000_0000},
      {6'd63, 32'h0000_0008, 6'd0,  2'd0, 1'b0, 6'd3,  32'h0000_0008},
      {6'd20, 32'h0000_0000, 6'd0,  2'd0, 1'b1, 6'd20, 32'h0010_0000},
      {6'd20, 32'h0000_0028, 6'd0,  2'd0, 1'b1, 6'd20, 32'h0010_0028},
      {6'd20, 32'h0000_0000, 6'd20, 2'd0, 1'b0, 6'd20, 32'h0010_0000},
      {6'd20, 32'h0000_0000, 6'd19, 2'd0, 1'b1, 6'd20, 32'h0010_0000},
      {6'd20, 32'h0000_0000, 6'd0,  2'd2, 1'b0, 6'd20, 32'h0010_0000},
      {6'd20, 32'h0000_0000, 6'd0,  2'd1, 1'b0, 6'd20, 32'h0010_0000},
      {6'd2,  32'h0000_0028, 6'd0,  2'd0, 1'b1, 6'd5,  32'h0000_0028},
      {6'd2,  32'h0000_0028, 6'd5,  2'd0, 1'b0, 6'd5,  32'h0000_0028},
      {6'd2,  32'h0000_8000, 6'd0,  2'd0, 1'b1, 6'd15, 32'h0000_8000},
      {6'd2,  32'h0000_0001, 6'd0,  2'd0, 1'b0, 6'd0,  32'h0000_0000},
      {6'd31, 32'h0000_0000, 6'd0,  2'd0, 1'b1, 6'd31, 32'h8000_0000},
      {6'd2,  32'h0001_0000, 6'd0,  2'd0, 1'b0, 6'd0,  32'h0000_0000}
   };

   task automatic chk(input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_req(input logic [1:0] op, input logic [LW-1:0] l,
                         input logic [IW-1:0] i);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_lvl = l; req_idx = i;
      @(negedge clk);
      req_valid = 1'b0; req_op = 2'b00;
   endtask

   task automatic pulse_take();
      @(negedge clk); take = 1'b1;
      @(negedge clk); take = 1'b0;
   endtask

   task automatic pulse_upd();
      @(negedge clk); upd = 1'b1;
      @(negedge clk); upd = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 status", 64'(lvl_status), 64'h0);
      chk("R12 irq", 64'(irq), 64'h0);
      chk("R12 info_pend", 64'(info_pend), 64'h0);
      chk("R12 int_id", 64'(int_id), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: R4 R5 R6 R7 R8
      for (int v = 0; v < NV; v++) begin
         logic [VW-1:0] e;
         e = VEC[v];
         do_req(2'b11, '0, '0);
         if (e[84:79] != 6'd63) do_req(2'b01, e[84:79], 7'd0);
         sw_req = e[78:47]; cur_ipl = e[46:41]; pc_low = e[40:39];
         @(negedge clk);
         chk($sformatf("R4/R5/R8 irq vec %0d", v), 64'(irq), 64'(e[38]));
         chk($sformatf("R6/R7 level vec %0d", v), 64'(calc_level), 64'(e[37:32]));
         chk($sformatf("R6/R7 summary vec %0d", v), 64'(calc_summary), 64'(e[31:0]));
      end
      sw_req = '0; cur_ipl = '0; pc_low = 2'b00;
      do_req(2'b11, '0, '0);

      // R1 post
      do_req(2'b01, 6'd17, 7'd40);
      chk("R1 status", 64'(lvl_status), 64'(32'h1 << 17));
      // R2 partial and full clear
      do_req(2'b01, 6'd17, 7'd3);
      do_req(2'b10, 6'd17, 7'd40);
      chk("R2 still set", 64'(lvl_status), 64'(32'h1 << 17));
      do_req(2'b10, 6'd17, 7'd3);
      chk("R2 emptied", 64'(lvl_status), 64'h0);
      // R3 clear-all
      do_req(2'b01, 6'd5, 7'd63);
      do_req(2'b01, 6'd25, 7'd0);
      chk("R3 before", 64'(lvl_status), 64'(32'h0200_0020));
      do_req(2'b11, '0, '0);
      chk("R3 after", 64'(lvl_status), 64'h0);

      // R10 out-of-range requests
      do_req(2'b01, 6'd40, 7'd0);
      chk("R10 err lvl", 64'(err), 64'h1);
      chk("R10 status lvl", 64'(lvl_status), 64'h0);
      @(negedge clk);
      chk("R10 err pulse", 64'(err), 64'h0);
      do_req(2'b01, 6'd10, 7'd64);
      chk("R10 err idx", 64'(err), 64'h1);
      chk("R10 status idx", 64'(lvl_status), 64'h0);

      // R9 accept then update
      do_req(2'b01, 6'd22, 7'd9);
      chk("R9 irq", 64'(irq), 64'h1);
      pulse_take();
      chk("R9 pend set", 64'(info_pend), 64'h1);
      chk("R9 id before upd", 64'(int_id), 64'h0);
      pulse_upd();
      chk("R9 id", 64'(int_id), 64'd22);
      chk("R9 status", 64'(int_status), 64'(32'h1 << 22));
      chk("R9 pend clear", 64'(info_pend), 64'h0);

      // R11 stray update
      do_req(2'b11, '0, '0);
      pulse_upd();
      chk("R11 err", 64'(err), 64'h1);
      chk("R11 id kept", 64'(int_id), 64'd22);
      chk("R11 status kept", 64'(int_status), 64'(32'h1 << 22));

      // R12 reset mid-run
      do_req(2'b01, 6'd30, 7'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R12 status after reset", 64'(lvl_status), 64'h0);
      chk("R12 id after reset", 64'(int_id), 64'h0);
      chk("R12 err after reset", 64'(err), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end

endmodule